// File: doc/BRIEF.md
# Write Progress Status Readback

This block sits on the read side of a byte-programmable non-volatile memory and decides what the shared data bus carries during a read. A read is open while both active-low selects, chip select and output select, are low; the block then enables the bus drivers and returns a byte. When either select is high the drivers are off and the data output is held at zero.

While the write controller reports that a programming cycle is running, reads no longer return array contents. They return a status byte instead, with two indicators. The top bit is a polling bit: it reads as the inverse of bit 7 of the byte being programmed whenever the host reads that byte's address. The bit below it is a toggle bit that changes value once per read access for as long as programming lasts. The write controller also supplies a level that marks a rejected write in the protected state; while it is high, the polling bit gives the true bit instead of the inverse. When programming ends, reads return array data again and the toggle bit holds.

All selects and data are sampled on the rising clock edge, and the bus byte and its enable are registered, so a read result appears on the edge that samples its inputs.

Top module: `wr_status_readback`

## Requirements
- R1: While reset is high and on the first edge after it, `bus_oe` is 0 and `bus_dout` is 0.
- R2: `bus_oe` is 1 after an edge that samples `cs_n`=0 and `rd_n`=0. It is 0 after an edge that samples either select at 1, and `bus_dout` is then 0.
- R3: With `prog_busy`=0, an open read returns `array_rdata` on `bus_dout`.
- R4: With `prog_busy`=1, `poll_block`=0 and `rd_addr` equal to `last_addr`, `bus_dout[7]` is the inverse of `last_data[7]`.
- R5: With `prog_busy`=1, `poll_block`=0 and `rd_addr` different from `last_addr`, `bus_dout[7]` is 0.
- R6: With `prog_busy`=1, `bus_dout[6]` inverts on the first edge of every read access, where an access starts when both selects are sampled low after at least one of them was high. It is constant for the rest of that access. A cycle where only one select is low is not an access.
- R7: With `prog_busy`=1, `bus_dout[5:0]` is 0 during a read.
- R8: With `prog_busy`=1 and `poll_block`=1, `bus_dout[7]` is `last_data[7]` unchanged, and the toggle bit still follows R6.
- R9: After `prog_busy` falls, reads return array data and the toggle state no longer changes. The next programming cycle continues from the held toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output select, active low |
| rd_addr | input | AW | Address of the current read |
| array_rdata | input | 8 | Stored byte at `rd_addr` |
| prog_busy | input | 1 | Programming cycle running |
| last_addr | input | AW | Address of the byte being programmed |
| last_data | input | 8 | Byte being programmed |
| poll_block | input | 1 | Rejected protected-state write: suppress the polling inversion |
| bus_dout | output | 8 | Data for the bus drivers |
| bus_oe | output | 1 | Bus driver enable |

## Verification
Every result is due one clock edge after the inputs that cause it: the bench drives on the falling edge and compares on the next falling edge, after exactly one rising edge has registered the byte. The toggle bit's expected value comes from a counter in the bench that inverts once at the start of each access made while busy. The bench checks that value on every cycle of an access, so a toggle that moves late or fires twice shows up as a mismatch. The end of each access is checked on the edge that samples the raised select.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int BYTE_W = 8;
  localparam int POLL_POS = BYTE_W - 1;
  localparam int TOG_POS = BYTE_W - 2;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic poll;
    logic tog;
  } stat_bits_t;
endpackage

// File: rtl/wrs_select_track.sv
module wrs_select_track (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  output logic rd_now,
  output logic rd_start
);
  logic rd_q;

  assign rd_now   = ~cs_n & ~rd_n;
  assign rd_start = rd_now & ~rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_now;
  end

  // R6: a start pulse never lasts two cycles
  p_single_start_r6: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);
endmodule

// File: rtl/wrs_toggle.sv
module wrs_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_start,
  output logic tog_next
);
  logic tog_q;

  assign tog_next = (busy && rd_start) ? ~tog_q : tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next;
  end

  // R6: the toggle flips on each busy access start
  p_tog_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_start) |=> (tog_q != $past(tog_q)));
  // R9: without programming the toggle holds
  p_tog_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tog_q));
endmodule

// File: rtl/wrs_out_stage.sv
module wrs_out_stage
  import wrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  rd_src_e           src,
  input  logic [BYTE_W-1:0] array_rdata,
  input  stat_bits_t        stat,
  output logic [BYTE_W-1:0] dout,
  output logic              oe
);
  logic [BYTE_W-1:0] stat_byte;

  always_comb begin
    stat_byte = '0;
    stat_byte[POLL_POS] = stat.poll;
    stat_byte[TOG_POS]  = stat.tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      case (src)
        SRC_ARRAY:  begin dout <= array_rdata; oe <= 1'b1; end
        SRC_STATUS: begin dout <= stat_byte;   oe <= 1'b1; end
        default:    begin dout <= '0;          oe <= 1'b0; end
      endcase
    end
  end

  // R7: status bytes carry zeros in the low bits
  p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_STATUS) |=> (dout[TOG_POS-1:0] == '0));
  // R2: a closed bus carries zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (dout == '0));
endmodule

// File: rtl/wr_status_readback.sv
module wr_status_readback
  import wrs_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    array_rdata,
  input  logic          prog_busy,
  input  logic [AW-1:0] last_addr,
  input  logic [7:0]    last_data,
  input  logic          poll_block,
  output logic [7:0]    bus_dout,
  output logic          bus_oe
);
  logic       rd_now;
  logic       rd_start;
  logic       tog_next;
  logic       addr_hit;
  rd_src_e    src;
  stat_bits_t stat;

  wrs_select_track u_sel (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .rd_now(rd_now), .rd_start(rd_start)
  );

  wrs_toggle u_tog (
    .clk(clk), .rst(rst), .busy(prog_busy), .rd_start(rd_start),
    .tog_next(tog_next)
  );

  assign addr_hit = (rd_addr == last_addr);

  always_comb begin
    if (poll_block)    stat.poll = last_data[POLL_POS];
    else if (addr_hit) stat.poll = ~last_data[POLL_POS];
    else               stat.poll = 1'b0;
    stat.tog = tog_next;
  end

  always_comb begin
    if (!rd_now)        src = SRC_OFF;
    else if (prog_busy) src = SRC_STATUS;
    else                src = SRC_ARRAY;
  end

  wrs_out_stage u_out (
    .clk(clk), .rst(rst), .src(src), .array_rdata(array_rdata),
    .stat(stat), .dout(bus_dout), .oe(bus_oe)
  );

  // R2: a raised select closes the bus on the next edge
  p_bus_off_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !bus_oe);
  // R3: idle reads pass array data through
  p_array_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !prog_busy) |=> (bus_dout == $past(array_rdata)));
  // R4: polling inversion on the programmed address
  p_poll_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && prog_busy && !poll_block && rd_addr == last_addr)
      |=> (bus_dout[7] == ~$past(last_data[7])));
  // R8: blocked polling reports the true bit
  p_poll_block_r8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && prog_busy && poll_block)
      |=> (bus_dout[7] == $past(last_data[7])));
endmodule

// File: tb/tb_wr_status_readback.sv
`timescale 1ns/1ps
module tb_wr_status_readback;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, rd_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, last_addr = '0;
  logic [7:0]    array_rdata = '0, last_data = '0;
  logic          prog_busy = 1'b0, poll_block = 1'b0;
  logic [7:0]    bus_dout;
  logic          bus_oe;

  int checks = 0;
  int errors = 0;
  logic tog_m = 1'b0;

  always #2.5 clk = ~clk;

  wr_status_readback #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .rd_addr(rd_addr),
    .array_rdata(array_rdata), .prog_busy(prog_busy), .last_addr(last_addr),
    .last_data(last_data), .poll_block(poll_block),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got oe/data %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input logic [AW-1:0] a);
    logic p;
    if (poll_block)          p = last_data[7];
    else if (a == last_addr) p = ~last_data[7];
    else                     p = 1'b0;
    return {p, tog_m, 6'b0};
  endfunction

  // entered at a falling edge
  task automatic access(input logic [AW-1:0] a, input logic [7:0] arr,
                        input int len, input bool_cs_end, input string req);
    logic [7:0] e;
    cs_n = 1'b0; rd_n = 1'b0; rd_addr = a; array_rdata = arr;
    if (prog_busy) tog_m = ~tog_m;
    e = prog_busy ? status_exp(a) : arr;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      check(req, {bus_oe, bus_dout}, {1'b1, e});
    end
    if (bool_cs_end) cs_n = 1'b1; else rd_n = 1'b1;
    @(negedge clk);
    check("R2 close", {bus_oe, bus_dout}, 9'h000);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {bus_oe, bus_dout}, 9'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {bus_oe, bus_dout}, 9'h000);

    // R3: idle reads over every address
    for (int a = 0; a < 16; a++)
      access(AW'(a), 8'(a * 37 + 5), 2, a[0], "R3 array read");

    // R2: one select alone opens nothing
    cs_n = 1'b0; rd_addr = '0;
    @(negedge clk);
    check("R2 cs only", {bus_oe, bus_dout}, 9'h000);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check("R2 rd only", {bus_oe, bus_dout}, 9'h000);
    rd_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7 R8: sweep programmed data, block level and all addresses
    for (int d = 0; d < 4; d++) begin
      for (int b = 0; b < 2; b++) begin
        prog_busy = 1'b1; poll_block = b[0];
        last_data = 8'(d * 67 + 3) ^ {d[0], 7'b0};
        last_addr = AW'(d * 5 + 2);
        for (int a = 0; a < 16; a++)
          access(AW'(a), 8'hA5, 1 + (a % 3), a[1],
                 b[0] ? "R8 blocked poll"
                      : (AW'(a) == last_addr ? "R4 poll invert" : "R5 other addr"));
        // R6: a single select between accesses must not count
        rd_n = 1'b0; @(negedge clk);
        check("R6 no access", {bus_oe, bus_dout}, 9'h000);
        rd_n = 1'b1;
        access(last_addr, 8'h00, 3, 1'b1, "R6 R7 toggle");
        // R9: programming ends, reads return data and toggle holds
        prog_busy = 1'b0; poll_block = 1'b0;
        access(last_addr, last_data, 2, 1'b0, "R9 true data");
        access(AW'(1), 8'h3C, 1, 1'b1, "R9 no toggle");
      end
    end

    // R9: back to back accesses with the toggle held across an idle gap
    prog_busy = 1'b1; last_addr = '0; last_data = 8'h80;
    access('0, 8'h11, 1, 1'b1, "R4 R6 resume");
    access('0, 8'h11, 1, 1'b0, "R4 R6 second");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule